// File: doc/BRIEF.md
# Folded Symmetric Decimating FIR Filter for I/Q Streams

This block filters a complex baseband stream with a linear-phase FIR whose impulse response is symmetric, and it lowers the sample rate as it goes. Since the response mirrors about its centre, only the unique half of the coefficients is kept. For each folded pair, the two mirrored delay-line samples are added and the sum is multiplied once by the shared coefficient. The centre tap has no partner and is applied once. A single multiplier per channel is shared across every folded pair over successive clocks. The in-phase and quadrature channels run side by side from the same coefficient set.

A parameter picks one of two builds. A 21-tap build always keeps one input in two. A 63-tap build keeps one input in two or one in four, and a control pin chooses between these at run time. Coefficients are loaded through a small write port. A write only lands while no output is being computed. The output is the full-precision sum with no rounding, which is left to a later stage. Valid inputs must be spaced more than (taps+1)/2 + 2 clocks apart, so that each computation ends before the next sample shifts the delay line.

Top module: `sym_dec_fir`

## Requirements
- R1: After reset `outValid`, `coefErr`, `outI` and `outQ` are 0, every delay-line sample is 0 and every stored coefficient is 0.
- R2: Each output equals the exact sum over all N taps of h[j]·x[n-j], where x[n] is the newest input. The response is h[k] = h[N-1-k] = coefficient k for k < (N+1)/2, so coefficient (N-1)/2 weights only the centre sample.
- R3: The quadrature output uses the same coefficients as the in-phase output and its own data, computed in the same cycles.
- R4: In the 63-tap build, `decBy4`=0 gives one output per 2 valid inputs and `decBy4`=1 gives one output per 4. After reset, the first output follows the 2nd (or 4th) valid input.
- R5: The 21-tap build produces one output per 2 valid inputs whatever the value of `decBy4`.
- R6: `outValid` is a single-cycle pulse. It rises (N+1)/2 clocks after the rising edge that captured the input completing a decimation group.
- R7: While idle, a write with `coefAddr` < (N+1)/2 stores `coefData` (16-bit two's complement) as that coefficient. A write to any higher address changes nothing.
- R8: A write while an output is being computed is ignored and sets `coefErr`. `coefErr` stays 1 until reset, including through later accepted writes.
- R9: The accumulator never overflows. Full-scale inputs of -2^20 and 2^20-1 with all coefficients at -32768 give the exact product sums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| inI | input | DATA_W (21) | In-phase sample, two's complement |
| inQ | input | DATA_W (21) | Quadrature sample, two's complement |
| decBy4 | input | 1 | 63-tap build: 1 = keep one in four, 0 = one in two |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | ADDR_W (6) | Coefficient index |
| coefData | input | COEF_W (16) | Coefficient value, two's complement |
| outValid | output | 1 | Output strobe at the decimated rate |
| outI | output | ACC_W (43 for 63 taps) | In-phase full-precision sum |
| outQ | output | ACC_W (43 for 63 taps) | Quadrature full-precision sum |
| coefErr | output | 1 | Sticky flag for a write made while busy |

## Verification
A wrong pairing index or a misplaced centre test shows up in the very first output after reset as a wrong impulse response, seen at the output coefficient by coefficient. A decimation phase counter that drifts moves the output pulse to the wrong input within one group of 2 or 4 samples. A step counter that ends early or late moves the pulse away from its fixed (N+1)/2-clock delay and corrupts the sum in the same output. A write-gating fault appears as a changed response in the next output after the write, or as a missing or spurious error flag one clock after the strobe.

// File: rtl/fir_pkg.sv
package fir_pkg;

  // Strobes handed from the sequencer to each channel datapath.
  typedef struct packed {
    logic shift;  // push the new sample into the delay line
    logic clear;  // zero the accumulator before a new sum
    logic mac;    // accumulate one folded pair this cycle
    logic last;   // final pair: capture the finished sum
  } firStrobes_t;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } firState_t;

endpackage

// File: rtl/sym_fir_ctrl.sv
module sym_fir_ctrl
  import fir_pkg::*;
#(
  parameter int NUM_TAPS = 63,
  parameter int IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             decBy4,
  input  logic             coefWe,
  output firStrobes_t      strb,
  output logic [IDX_W-1:0] idx,
  output logic             coefAccept,
  output logic             coefErr,
  output logic             outValid
);

  localparam int PAIRS = (NUM_TAPS + 1) / 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAIRS - 1);

  firState_t  state;
  logic [1:0] phase;
  logic [1:0] phaseMax;
  logic       running;
  logic       boundary;
  logic       lastStep;

  // Decimation choice: the short build is fixed, the long one follows decBy4.
  generate
    if (NUM_TAPS == 21) begin : g_fixed_two
      logic unusedSel;
      assign unusedSel = decBy4;
      assign phaseMax  = 2'd1;
    end else begin : g_sel_rate
      assign phaseMax = decBy4 ? 2'd3 : 2'd1;
    end
  endgenerate

  assign running  = (state == S_RUN);
  assign boundary = inValid && (phase >= phaseMax);
  assign lastStep = running && (idx == LAST_IDX);

  always_comb begin
    strb.shift = inValid;
    strb.clear = boundary && !running;
    strb.mac   = running;
    strb.last  = lastStep;
  end

  assign coefAccept = coefWe && !running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      phase    <= 2'd0;
      idx      <= '0;
      coefErr  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (inValid) begin
        phase <= boundary ? 2'd0 : phase + 2'd1;
      end
      case (state)
        S_IDLE: begin
          if (boundary) begin
            state <= S_RUN;
            idx   <= '0;
          end
        end
        S_RUN: begin
          if (idx == LAST_IDX) begin
            state <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (coefWe && running) begin
        coefErr <= 1'b1;
      end
      outValid <= lastStep;
    end
  end

endmodule

// File: rtl/sym_fir_coef.sv
module sym_fir_coef #(
  parameter int PAIRS  = 32,
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 6,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic signed [COEF_W-1:0] wrData,
  input  logic [IDX_W-1:0]         rdIdx,
  output logic signed [COEF_W-1:0] rdCoef
);

  logic signed [COEF_W-1:0] bank [PAIRS];
  logic                     inRange;

  assign inRange = (wrAddr < ADDR_W'(PAIRS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < PAIRS; k++) begin
        bank[k] <= '0;
      end
    end else if (wrEn && inRange) begin
      bank[wrAddr[IDX_W-1:0]] <= wrData;
    end
  end

  assign rdCoef = bank[rdIdx];

endmodule

// File: rtl/sym_fir_path.sv
module sym_fir_path
  import fir_pkg::*;
#(
  parameter int NUM_TAPS = 63,
  parameter int DATA_W   = 21,
  parameter int COEF_W   = 16,
  parameter int IDX_W    = 5,
  parameter int ACC_W    = 43
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  firStrobes_t              strb,
  input  logic [IDX_W-1:0]         idx,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  result
);

  localparam int CENTER = (NUM_TAPS - 1) / 2;
  localparam int TAP_W  = $clog2(NUM_TAPS);
  localparam int SUM_W  = DATA_W + 1;
  localparam int PROD_W = SUM_W + COEF_W;

  logic signed [DATA_W-1:0] line [NUM_TAPS];
  logic [TAP_W-1:0]         nearIdx;
  logic [TAP_W-1:0]         farIdx;
  logic signed [DATA_W-1:0] nearTap;
  logic signed [DATA_W-1:0] farTap;
  logic signed [SUM_W-1:0]  pairSum;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  accNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_TAPS; k++) begin
        line[k] <= '0;
      end
    end else if (strb.shift) begin
      line[0] <= sampleIn;
      for (int k = 1; k < NUM_TAPS; k++) begin
        line[k] <= line[k-1];
      end
    end
  end

  // Fold: tap idx pairs with its mirror; the centre stands alone.
  assign nearIdx = TAP_W'(idx);
  assign farIdx  = TAP_W'(NUM_TAPS - 1) - nearIdx;
  assign nearTap = line[nearIdx];
  assign farTap  = line[farIdx];

  always_comb begin
    if (idx == IDX_W'(CENTER)) begin
      pairSum = {nearTap[DATA_W-1], nearTap};
    end else begin
      pairSum = {nearTap[DATA_W-1], nearTap} + {farTap[DATA_W-1], farTap};
    end
  end

  assign prod    = PROD_W'(pairSum) * PROD_W'(coef);
  assign accNext = acc + ACC_W'(prod);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      result <= '0;
    end else begin
      if (strb.clear) begin
        acc <= '0;
      end else if (strb.mac) begin
        acc <= accNext;
      end
      if (strb.last) begin
        result <= accNext;
      end
    end
  end

endmodule

// File: rtl/sym_dec_fir.sv
module sym_dec_fir
  import fir_pkg::*;
#(
  parameter int NUM_TAPS = 63,
  parameter int DATA_W   = 21,
  parameter int COEF_W   = 16,
  parameter int ADDR_W   = 6,
  parameter int ACC_W    = DATA_W + 1 + COEF_W + $clog2((NUM_TAPS + 1) / 2)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     decBy4,
  input  logic                     coefWe,
  input  logic [ADDR_W-1:0]        coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outI,
  output logic signed [ACC_W-1:0]  outQ,
  output logic                     coefErr
);

  localparam int PAIRS = (NUM_TAPS + 1) / 2;
  localparam int IDX_W = $clog2(PAIRS);

  firStrobes_t              strb;
  logic [IDX_W-1:0]         idx;
  logic                     coefAccept;
  logic signed [COEF_W-1:0] coef;
  logic signed [DATA_W-1:0] chanIn  [2];
  logic signed [ACC_W-1:0]  chanOut [2];

  sym_fir_ctrl #(
    .NUM_TAPS(NUM_TAPS),
    .IDX_W   (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .decBy4    (decBy4),
    .coefWe    (coefWe),
    .strb      (strb),
    .idx       (idx),
    .coefAccept(coefAccept),
    .coefErr   (coefErr),
    .outValid  (outValid)
  );

  sym_fir_coef #(
    .PAIRS (PAIRS),
    .IDX_W (IDX_W),
    .ADDR_W(ADDR_W),
    .COEF_W(COEF_W)
  ) u_coef (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (coefAccept),
    .wrAddr(coefAddr),
    .wrData(coefData),
    .rdIdx (idx),
    .rdCoef(coef)
  );

  assign chanIn[0] = inI;
  assign chanIn[1] = inQ;

  generate
    for (genvar c = 0; c < 2; c++) begin : g_chan
      sym_fir_path #(
        .NUM_TAPS(NUM_TAPS),
        .DATA_W  (DATA_W),
        .COEF_W  (COEF_W),
        .IDX_W   (IDX_W),
        .ACC_W   (ACC_W)
      ) u_path (
        .clk     (clk),
        .rstN    (rstN),
        .strb    (strb),
        .idx     (idx),
        .sampleIn(chanIn[c]),
        .coef    (coef),
        .result  (chanOut[c])
      );
    end
  endgenerate

  assign outI = chanOut[0];
  assign outQ = chanOut[1];

endmodule

// File: rtl/sym_dec_fir_chk.sv
module sym_dec_fir_chk #(
  parameter int NUM_TAPS = 63
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic outValid,
  input logic coefWe,
  input logic coefErr
);

  localparam int PAIRS = (NUM_TAPS + 1) / 2;
  localparam int CNT_W = $clog2(PAIRS + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] sinceIn;
  logic [2:0]       inCnt;

  // Clocks since the latest valid input, saturating.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceIn <= CNT_MAX;
    end else if (inValid) begin
      sinceIn <= '0;
    end else if (sinceIn != CNT_MAX) begin
      sinceIn <= sinceIn + 1'b1;
    end
  end

  // Valid inputs seen since the previous output pulse.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inCnt <= 3'd0;
    end else if (outValid) begin
      inCnt <= inValid ? 3'd1 : 3'd0;
    end else if (inValid && inCnt != 3'd7) begin
      inCnt <= inCnt + 3'd1;
    end
  end

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (sinceIn == CNT_W'(PAIRS)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    coefErr |=> coefErr);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coefErr) |-> $past(coefWe));

  p_group_size_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inCnt == 3'd2 || inCnt == 3'd4));

  generate
    if (NUM_TAPS == 21) begin : g_short
      p_fixed_rate_r5: assert property (@(posedge clk) disable iff (!rstN)
        outValid |-> (inCnt == 3'd2));
    end
  endgenerate

endmodule

bind sym_dec_fir sym_dec_fir_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .coefWe  (coefWe),
  .coefErr (coefErr)
);

// File: tb/sym_dec_fir_tb.sv
module sym_dec_fir_tb;

  localparam int GAP = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic decBy4 = 1'b0;
  logic coefWe = 1'b0;
  logic signed [20:0] inI = '0;
  logic signed [20:0] inQ = '0;
  logic [5:0] coefAddr = '0;
  logic signed [15:0] coefData = '0;

  logic outValid63, coefErr63;
  logic signed [42:0] outI63, outQ63;
  logic outValid21, coefErr21;
  logic signed [41:0] outI21, outQ21;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  string tag = "R2";

  longint histI [63];
  longint histQ [63];
  longint cm63 [32];
  longint cm21 [11];
  int ph63 = 0;
  int ph21 = 0;

  longint q63I[$], q63Q[$], q63C[$];
  longint q21I[$], q21Q[$], q21C[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sym_dec_fir #(.NUM_TAPS(63)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .decBy4(decBy4), .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid63), .outI(outI63), .outQ(outQ63), .coefErr(coefErr63)
  );

  sym_dec_fir #(.NUM_TAPS(21)) u_dut21 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .decBy4(decBy4), .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid21), .outI(outI21), .outQ(outQ21), .coefErr(coefErr21)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic longint firSum(input int n, input bit useQ);
    longint s = 0;
    for (int j = 0; j < n; j++) begin
      int k = (j < (n + 1) / 2) ? j : n - 1 - j;
      longint c = (n == 63) ? cm63[k] : cm21[k];
      s += c * (useQ ? histQ[j] : histI[j]);
    end
    return s;
  endfunction

  task automatic resetDut(input bit sel4);
    @(negedge clk);
    rstN = 1'b0;
    decBy4 = sel4;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int j = 0; j < 63; j++) begin histI[j] = 0; histQ[j] = 0; end
    for (int k = 0; k < 32; k++) cm63[k] = 0;
    for (int k = 0; k < 11; k++) cm21[k] = 0;
    ph63 = 0;
    ph21 = 0;
    @(negedge clk);
    // R1: quiet outputs and clear flag right after reset
    check(outValid63 == 1'b0, "R1 outValid 63", longint'(outValid63), 0);
    check(coefErr63 == 1'b0, "R1 coefErr 63", longint'(coefErr63), 0);
    check(outI63 == '0, "R1 outI 63", longint'(outI63), 0);
    check(outQ63 == '0, "R1 outQ 63", longint'(outQ63), 0);
    check(outValid21 == 1'b0, "R1 outValid 21", longint'(outValid21), 0);
    check(coefErr21 == 1'b0, "R1 coefErr 21", longint'(coefErr21), 0);
    check(outI21 == '0, "R1 outI 21", longint'(outI21), 0);
    check(outQ21 == '0, "R1 outQ 21", longint'(outQ21), 0);
  endtask

  task automatic writeCoef(input int addr, input int data, input bit whileBusy);
    @(negedge clk);
    coefWe = 1'b1;
    coefAddr = 6'(addr);
    coefData = 16'(data);
    @(negedge clk);
    coefWe = 1'b0;
    if (!whileBusy) begin
      if (addr < 32) cm63[addr] = longint'($signed(16'(data)));
      if (addr < 11) cm21[addr] = longint'($signed(16'(data)));
    end
  endtask

  task automatic sendSample(input int vi, input int vq, input bit busyWrite);
    bit b63, b21;
    @(negedge clk);
    inValid = 1'b1;
    inI = 21'(vi);
    inQ = 21'(vq);
    for (int j = 62; j > 0; j--) begin histI[j] = histI[j-1]; histQ[j] = histQ[j-1]; end
    histI[0] = vi;
    histQ[0] = vq;
    b63 = (ph63 >= (decBy4 ? 3 : 1));
    ph63 = b63 ? 0 : ph63 + 1;
    b21 = (ph21 >= 1);
    ph21 = b21 ? 0 : ph21 + 1;
    if (b63) begin
      q63I.push_back(firSum(63, 1'b0));
      q63Q.push_back(firSum(63, 1'b1));
      q63C.push_back(longint'(cyc + 1 + 32));
    end
    if (b21) begin
      q21I.push_back(firSum(21, 1'b0));
      q21Q.push_back(firSum(21, 1'b1));
      q21C.push_back(longint'(cyc + 1 + 11));
    end
    @(negedge clk);
    inValid = 1'b0;
    if (busyWrite) begin
      writeCoef(5, 12345, 1'b1);
      // R8: write during a computation raises the flag in both builds
      check(coefErr63 == 1'b1, "R8 coefErr 63 after busy write", longint'(coefErr63), 1);
      check(coefErr21 == 1'b1, "R8 coefErr 21 after busy write", longint'(coefErr21), 1);
    end
    repeat (GAP) @(negedge clk);
  endtask

  // Monitors: pop the scoreboard as each build produces a result.
  always @(negedge clk) begin
    if (rstN && outValid63) begin
      if (q63I.size() == 0) begin
        check(1'b0, "R4 unexpected 63-tap output", 1, 0);
      end else begin
        check(longint'(outI63) == q63I[0], {tag, " R2 63-tap I"}, longint'(outI63), q63I[0]);
        check(longint'(outQ63) == q63Q[0], {tag, " R3 63-tap Q"}, longint'(outQ63), q63Q[0]);
        check(longint'(cyc) == q63C[0], "R6 63-tap output cycle", longint'(cyc), q63C[0]);
        void'(q63I.pop_front());
        void'(q63Q.pop_front());
        void'(q63C.pop_front());
      end
    end
    if (rstN && outValid21) begin
      if (q21I.size() == 0) begin
        check(1'b0, "R5 unexpected 21-tap output", 1, 0);
      end else begin
        check(longint'(outI21) == q21I[0], {tag, " R5 21-tap I"}, longint'(outI21), q21I[0]);
        check(longint'(outQ21) == q21Q[0], {tag, " R3 21-tap Q"}, longint'(outQ21), q21Q[0]);
        check(longint'(cyc) == q21C[0], "R6 21-tap output cycle", longint'(cyc), q21C[0]);
        void'(q21I.pop_front());
        void'(q21Q.pop_front());
        void'(q21C.pop_front());
      end
    end
  end

  task automatic drained(input string what);
    check(q63I.size() == 0, {what, " 63-tap outputs missing"}, longint'(q63I.size()), 0);
    check(q21I.size() == 0, {what, " 21-tap outputs missing"}, longint'(q21I.size()), 0);
  endtask

  task automatic loadCoefs(input int seed);
    for (int k = 0; k < 32; k++) writeCoef(k, (k + 1) * seed - 700, 1'b0);
    writeCoef(40, 9999, 1'b0);  // R7: beyond both builds, must change nothing
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finishRun();
  end

  initial begin
    // Impulse and ramp: pairing, centre tap, address range (R2, R7)
    tag = "R2 R7";
    resetDut(1'b0);
    loadCoefs(37);
    sendSample(1000, -3000, 1'b0);
    for (int n = 0; n < 5; n++) sendSample(0, 0, 1'b0);
    for (int n = 0; n < 6; n++) sendSample(n * 12345 - 40000, 5 - n * 999, 1'b0);
    drained("R2");

    // Busy write ignored, flag sticky (R8)
    tag = "R8";
    resetDut(1'b0);
    loadCoefs(-53);
    sendSample(500, 600, 1'b0);
    sendSample(-700, 800, 1'b1);
    writeCoef(3, 99, 1'b0);
    check(coefErr63 == 1'b1, "R8 coefErr 63 stays after idle write", longint'(coefErr63), 1);
    check(coefErr21 == 1'b1, "R8 coefErr 21 stays after idle write", longint'(coefErr21), 1);
    for (int n = 0; n < 4; n++) sendSample(n * 3000 - 4000, 2000 - n * 777, 1'b0);
    drained("R8");

    // Decimate by four on the long build, short build stays at two (R4, R5)
    tag = "R4 R5";
    resetDut(1'b1);
    loadCoefs(211);
    for (int n = 0; n < 12; n++) sendSample(n * 70001 - 300000, 150000 - n * 9000, 1'b0);
    drained("R4 R5");

    // Full-scale accumulation (R9)
    tag = "R9";
    resetDut(1'b0);
    for (int k = 0; k < 32; k++) writeCoef(k, -32768, 1'b0);
    for (int n = 0; n < 64; n++) sendSample(-1048576, 1048575, 1'b0);
    drained("R9");

    finishRun();
  end

endmodule